// File: doc/BRIEF.md
# Two-wire serial memory slave read engine

This block is the slave side of a two-wire (I2C-style) bus in front of a small byte-wide memory. It watches the clock and data lines, finds Start and Stop conditions, and takes each command as a control byte followed by a device identity byte. A write command carries one more byte, a word address, which moves the internal address pointer and nothing else. A read command streams bytes out of the memory through a synchronous read port. The slave pulls the data line low through a separate enable output, so the pad stays open-drain.

Three kinds of read are served. A current-address read starts at the pointer left by the previous access. A random read first sets the pointer with a write command, then uses a repeated Start and a read command. A sequential read keeps going for as long as the master acknowledges each byte. The pointer is kept across transactions and wraps from the top address to zero. The memory depth is a parameter (128 or 256 bytes), and it sets both the address width and the wrap point.

Top module: `eeprom_rd_slave`

## Requirements
- R1: After reset the data line is released, no memory read is requested and the pointer is 0. A Start (data falling while the clock is high) begins a new command from any state. A Stop (data rising while the clock is high) returns the slave to idle. Both release the data line and leave the pointer unchanged.
- R2: The slave accepts a control byte whose upper seven bits equal CTRL_CODE (default 1010000, so 0xA0 writes and 0xA1 reads) and acknowledges it by holding data low through the ninth clock. Bit 0 of the control byte is the direction, and 1 means read.
- R3: The byte after the control byte must equal id_value_i to be acknowledged. If the control byte or the identity byte does not match, the slave gives no acknowledge, drives nothing and ignores the bus until the next Start.
- R4: In a write command the slave acknowledges the word-address byte and loads its low ADDR_W bits into the pointer. It does not acknowledge any later byte of that command.
- R5: After a read command is acknowledged, the slave sends the byte at the pointer, most significant bit first. The data line changes only while the clock is low.
- R6: The pointer advances by one after each byte sent. A current-address read therefore returns the byte after the last one read.
- R7: A master acknowledge (data low in the ninth clock of a data byte) makes the slave send the next sequential byte. A not-acknowledge makes it stop driving until the next Start.
- R8: The pointer wraps from DEPTH-1 to 0.
- R9: Each byte sent is fetched by a one-cycle mem_rd_o pulse carrying the pointer on mem_addr_o. The pulse is issued when the read command's identity byte is accepted, or when a master acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| id_value_i | input | 8 | Identity byte this slave answers to |
| mem_rd_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | ADDR_W | Memory read address (the pointer) |
| mem_data_i | input | 8 | Read data, valid the cycle after mem_rd_o |

## Verification
The assertions assume a well-formed bus. Both lines are high or low for many system clocks per phase, data moves only while the clock is low except to form Start and Stop, and read data arrives one cycle after each request. The bench drives the bus from tasks that change data a quarter bus period after each clock fall. It models the wired-AND line from its own release and the slave's pull-down, and answers read requests from a computed memory pattern after exactly one cycle. It never makes a Start or Stop while the slave may be driving.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ID,
    ST_WADDR,
    ST_RDATA
  } rd_state_t;

  // next pointer value with roll-over at the top of memory
  function automatic int unsigned wrap_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // control byte match: upper seven bits against the code, bit 0 is direction
  function automatic logic ctrl_match(input logic [7:0] b, input logic [6:0] code);
    return b[7:1] == code;
  endfunction

endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/rd_addr_ptr.sv
module rd_addr_ptr
  import eeprom_rd_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv_en,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_o <= '0;
    else if (load_en) ptr_o <= load_val;
    else if (adv_en)  ptr_o <= ADDR_W'(wrap_next(32'(ptr_o), DEPTH));
  end
endmodule

// File: rtl/rd_fetch_buf.sv
module rd_fetch_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_req,
  input  logic [7:0] mem_data_i,
  output logic [7:0] tx_byte_o
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      rd_q <= fetch_req;
      if (rd_q) tx_byte_o <= mem_data_i;
    end
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import eeprom_rd_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [6:0]  CTRL_CODE = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [7:0]        id_value_i,
  input  logic [7:0]        tx_byte_i,
  output logic              sda_low_o,
  output logic              fetch_o,
  output logic              ptr_adv_o,
  output logic              ptr_load_o,
  output logic [ADDR_W-1:0] load_val_o,
  output logic              byte_reject_o
);
  rd_state_t   state, pend;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic [6:0]  tx_sh;
  logic        rw_q;
  logic        receiving, byte_ok, ack_end;

  always_comb begin
    receiving = (state == ST_CTRL) || (state == ST_ID) || (state == ST_WADDR);
    unique case (state)
      ST_CTRL:  byte_ok = ctrl_match(shreg, CTRL_CODE);
      ST_ID:    byte_ok = (shreg == id_value_i);
      ST_WADDR: byte_ok = 1'b1;
      default:  byte_ok = 1'b0;
    endcase
    ack_end       = scl_fall && (bit_cnt == 4'd9);
    byte_reject_o = receiving && scl_fall && (bit_cnt == 4'd8) && !byte_ok;
  end

  assign load_val_o = shreg[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend       <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      tx_sh      <= '0;
      rw_q       <= 1'b0;
      sda_low_o  <= 1'b0;
      fetch_o    <= 1'b0;
      ptr_adv_o  <= 1'b0;
      ptr_load_o <= 1'b0;
    end else begin
      fetch_o    <= 1'b0;
      ptr_adv_o  <= 1'b0;
      ptr_load_o <= 1'b0;
      if (start_evt || stop_evt) begin
        state     <= start_evt ? ST_CTRL : ST_IDLE;
        bit_cnt   <= '0;
        sda_low_o <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (ack_end) begin
          state   <= pend;
          bit_cnt <= '0;
          if (pend == ST_RDATA) begin
            tx_sh     <= tx_byte_i[6:0];
            sda_low_o <= ~tx_byte_i[7];
          end else begin
            sda_low_o <= 1'b0;
          end
        end else if (receiving) begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (byte_ok) begin
              sda_low_o <= 1'b1;
              bit_cnt   <= 4'd9;
              unique case (state)
                ST_CTRL: begin
                  rw_q <= shreg[0];
                  pend <= ST_ID;
                end
                ST_ID: begin
                  pend    <= rw_q ? ST_RDATA : ST_WADDR;
                  fetch_o <= rw_q;
                end
                default: begin
                  ptr_load_o <= 1'b1;
                  pend       <= ST_IDLE;
                end
              endcase
            end else begin
              state <= ST_IDLE;
            end
          end
        end else begin
          if (scl_rise && bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) ptr_adv_o <= 1'b1;
          end else if (scl_rise && bit_cnt == 4'd8) begin
            if (!sda_s) begin
              fetch_o <= 1'b1;
              bit_cnt <= 4'd9;
              pend    <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end else if (scl_fall && bit_cnt == 4'd8) begin
            sda_low_o <= 1'b0;
          end else if (scl_fall && bit_cnt != 4'd0) begin
            sda_low_o <= ~tx_sh[6];
            tx_sh     <= {tx_sh[5:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave #(
  parameter int         DEPTH     = 256,
  parameter logic [6:0] CTRL_CODE = 7'h50,
  parameter int         ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [7:0]        id_value_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ptr_adv, ptr_load, byte_reject;
  logic [ADDR_W-1:0] load_val, ptr;
  logic [7:0] tx_byte;

  i2c_cond_det #(.SYNC_STAGES(2)) cond_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_rd_fsm #(.ADDR_W(ADDR_W), .CTRL_CODE(CTRL_CODE)) fsm_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .id_value_i(id_value_i), .tx_byte_i(tx_byte), .sda_low_o(sda_low_o),
    .fetch_o(mem_rd_o), .ptr_adv_o(ptr_adv), .ptr_load_o(ptr_load),
    .load_val_o(load_val), .byte_reject_o(byte_reject)
  );

  rd_addr_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .load_en(ptr_load), .load_val(load_val),
    .adv_en(ptr_adv), .ptr_o(ptr)
  );

  rd_fetch_buf buf_i (
    .clk(clk), .rst_n(rst_n), .fetch_req(mem_rd_o),
    .mem_data_i(mem_data_i), .tx_byte_o(tx_byte)
  );

  assign mem_addr_o = ptr;
endmodule

// File: rtl/eeprom_rd_chk.sv
module eeprom_rd_chk #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_low_o,
  input logic              mem_rd_o,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              byte_reject,
  input logic              ptr_adv,
  input logic [ADDR_W-1:0] ptr
);
  p_sda_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl_i);

  p_cond_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_low_o);

  p_cond_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> $stable(ptr));

  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_reject |=> (!sda_low_o && !mem_rd_o));

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && (32'(ptr) == DEPTH - 1)) |=> (ptr == '0));

  p_fetch_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);
endmodule

bind eeprom_rd_slave eeprom_rd_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .mem_rd_o(mem_rd_o), .start_evt(start_evt), .stop_evt(stop_evt),
  .byte_reject(byte_reject), .ptr_adv(ptr_adv), .ptr(ptr)
);

// File: tb/eeprom_rd_slave_tb_top.sv
`timescale 1ns/1ps
module eeprom_rd_slave_tb_top;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int Q      = 8;
  localparam logic [7:0] DEV_ID = 8'h3C;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 8'd1}, '{8'h10, 8'd3}, '{8'h7E, 8'd2},
    '{8'hFE, 8'd3}, '{8'h55, 8'd1}, '{8'h80, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_low;
  logic mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_q = '0;
  wire sda_line = sda_m & ~sda_low;

  int n_chk = 0, n_err = 0, rd_cnt = 0, phase_viol = 0;
  int exp_ptr = 0;
  logic prev_low = 1'b0;

  always #10 clk = ~clk;

  eeprom_rd_slave #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_low_o(sda_low), .id_value_i(DEV_ID), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_data_i(mem_q)
  );

  function automatic logic [7:0] mem_f(input int a);
    return 8'(((a % DEPTH) * 37 + 11) ^ 8'hA5);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_q  <= mem_f(int'(mem_addr));
      rd_cnt <= rd_cnt + 1;
    end
    if (sda_low !== prev_low && scl) phase_viol <= phase_viol + 1;
    prev_low <= sda_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl = 1'b1; wq; sda_m = 1'b0; wq; scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
    end
    sda_m = 1'b1; wq; scl = 1'b1; wq;
    ack_n = sda_line;
    wq; scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input logic ack_n, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl = 1'b1; wq;
      b[i] = sda_line;
      wq; scl = 1'b0;
    end
    wq; sda_m = ack_n; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic ak;
    bus_start;
    send_byte(8'hA0, ak);  chk(ak == 1'b0, "R2 write ctrl ack", ak, 0);
    send_byte(DEV_ID, ak); chk(ak == 1'b0, "R3 id ack", ak, 0);
    send_byte(a, ak);      chk(ak == 1'b0, "R4 addr ack", ak, 0);
    exp_ptr = int'(a) % DEPTH;
  endtask

  task automatic read_run(input int cnt, input string tag);
    logic ak;
    logic [7:0] d;
    int rd0;
    bus_start;
    rd0 = rd_cnt;
    send_byte(8'hA1, ak);  chk(ak == 1'b0, "R2 read ctrl ack", ak, 0);
    send_byte(DEV_ID, ak); chk(ak == 1'b0, "R3 read id ack", ak, 0);
    for (int i = 0; i < cnt; i++) begin
      recv_byte(i == cnt - 1, d);
      chk(d == mem_f(exp_ptr), tag, d, mem_f(exp_ptr));
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    bus_stop;
    chk(rd_cnt - rd0 == cnt, "R9 fetch pulses", rd_cnt - rd0, cnt);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    logic ak;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk(sda_low == 1'b0, "R1 reset release", sda_low, 0);
    chk(mem_rd == 1'b0, "R1 reset no read", mem_rd, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6 current-address read after reset starts at 0
    read_run(1, "R6 first current read");

    // table of random + sequential reads, includes R8 wrap at FE
    for (int v = 0; v < 6; v++) begin
      set_ptr(VECS[v].addr);
      read_run(int'(VECS[v].cnt), "R7 R8 sequential data");
    end

    // R6 current-address read continues past the last byte
    read_run(2, "R6 current read continues");

    // R3 wrong control byte: no ack, rest ignored, pointer kept
    bus_start;
    send_byte(8'hB1, ak);  chk(ak == 1'b1, "R3 bad ctrl nack", ak, 1);
    send_byte(DEV_ID, ak); chk(ak == 1'b1, "R3 ignored after reject", ak, 1);
    bus_stop;
    read_run(1, "R3 pointer kept after reject");

    // R3 wrong id: ctrl acked, id not, no data driven
    bus_start;
    send_byte(8'hA1, ak);     chk(ak == 1'b0, "R2 ctrl ack", ak, 0);
    send_byte(DEV_ID ^ 8'h01, ak); chk(ak == 1'b1, "R3 bad id nack", ak, 1);
    recv_byte(1'b0, d);       chk(d == 8'hFF, "R3 no data after bad id", d, 8'hFF);
    bus_stop;

    // R7 not-acknowledge ends driving
    bus_start;
    send_byte(8'hA1, ak);
    send_byte(DEV_ID, ak);
    recv_byte(1'b1, d);  chk(d == mem_f(exp_ptr), "R7 byte before nack", d, mem_f(exp_ptr));
    exp_ptr = (exp_ptr + 1) % DEPTH;
    recv_byte(1'b1, d);  chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    bus_stop;

    // R4 write command: extra byte not acked, pointer loaded, R1 kept across stop
    set_ptr(8'h20);
    send_byte(8'h99, ak); chk(ak == 1'b1, "R4 data byte not acked", ak, 1);
    bus_stop;
    read_run(1, "R4 R1 pointer from address byte");

    // R1 repeated start after write directly into read
    set_ptr(8'hFF);
    read_run(2, "R1 R8 repeated start wrap");

    chk(phase_viol == 0, "R5 data changes only with clock low", phase_viol, 0);
    chk(sda_low == 1'b0, "R1 idle release", sda_low, 0);
    finish_run;
  end
endmodule